// File: doc/BRIEF.md
# Converter Core Power Gate Controller

This block decides whether the conversion circuitry of a data converter receives power. Two sources can ask for power-down. One is an asynchronous power-down pin. The other is a pair of one-cycle strobes decoded from serial instructions: one asks to power down, the other asks to power up. The serial interface logic is never gated by this block. Only the conversion core is switched, through `core_en`.

The two requests are not simply ORed together. A software power-down is held in a sticky bit. Two things clear that bit: a software power-up strobe, or the pin going high and then low again. The pin always wins while it is high, so a software power-up has no effect during that time. After the core is enabled, a settle counter holds `core_ready` low for a fixed number of cycles. If power is removed while a conversion is in flight, `result_invalid` is raised. It stays up until a later conversion completes with the core powered.

The controller is a three-state machine:
- **OFF**: the core is unpowered.
- **WARM**: the core is powered and settling.
- **ON**: the core is powered and ready.

Its transitions are:
- **wake** (OFF→WARM): no power-down request remains.
- **settled** (WARM→ON): the settle count expires.
- **drop** (WARM→OFF or ON→OFF): a power-down request appears.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, `core_en`, `core_ready` and `result_invalid` are all 0.
- R2: The pin is passed through a SYNC_STAGES-flop synchroniser. Once the pin has been high for SYNC_STAGES+1 cycles, `core_en` is 0, whatever the software strobes do.
- R3: A software power-up strobe has no effect while the pin is high. `core_en` stays 0.
- R4: A software power-down strobe with the pin low drives `core_en` to 0 within two cycles. It keeps `core_en` at 0 for as long as no power-up strobe and no pin falling edge arrive.
- R5: A software power-up strobe, with the pin low, clears a pending software power-down. `core_en` then returns to 1.
- R6: After a software power-down, taking the pin high and then low clears the power-down. `core_en` returns to 1 without any power-up strobe.
- R7: A power-down strobe takes priority over any clear that arrives in the same cycle. That clear may be a power-up strobe or a synchronised pin falling edge.
- R8: `core_ready` rises exactly SETTLE_CYCLES cycles after `core_en` rises. `core_ready` is 0 whenever `core_en` is 0.
- R9: When `core_en` falls while `conv_busy` is 1, `result_invalid` becomes 1.
- R10: Once set, `result_invalid` is cleared only by `conv_done` while `core_en` is 1. A `conv_done` strobe while the core is unpowered leaves it at 1. A power loss while `conv_busy` is 0 does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_pin | input | 1 | Asynchronous hardware power-down request, high = down |
| sw_down_stb | input | 1 | One-cycle software power-down instruction strobe |
| sw_up_stb | input | 1 | One-cycle software power-up instruction strobe |
| conv_busy | input | 1 | Conversion in progress |
| conv_done | input | 1 | One-cycle strobe: a conversion finished |
| core_en | output | 1 | Power enable for the conversion core |
| core_ready | output | 1 | Core powered and settled |
| result_invalid | output | 1 | Next result is untrustworthy due to power loss mid-conversion |

## Verification
The bench builds the block with SYNC_STAGES=2 and SETTLE_CYCLES=5. The short settle window lets the bench count the exact ready delay after every wake-up. The two-flop chain fixes the cycle in which a synchronised pin falling edge appears. That lets the bench line up a power-down strobe with that edge and check the priority rule in R7.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WARM = 2'd1,
        ST_ON   = 2'd2
    } pdc_state_t;
endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= RESET_VAL;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= RESET_VAL;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pdc_settle.sv
module pdc_settle #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/pdc_invalid.sv
module pdc_invalid (
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic busy,
    input  logic done,
    input  logic powered,
    output logic invalid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                invalid <= 1'b0;
        else if (drop && busy)     invalid <= 1'b1;
        else if (done && powered)  invalid <= 1'b0;
    end
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl #(
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_pin,
    input  logic sw_down_stb,
    input  logic sw_up_stb,
    input  logic conv_busy,
    input  logic conv_done,
    output logic core_en,
    output logic core_ready,
    output logic result_invalid
);
    import pdc_pkg::*;

    pdc_state_t state, state_nx;
    logic pd_s, pd_d, pd_fall;
    logic sw_down;
    logic off_req, settled, drop;

    pdc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pd_pin), .q(pd_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_d <= 1'b1;
        else        pd_d <= pd_s;
    end
    assign pd_fall = pd_d && !pd_s;

    // sticky software request; a new power-down beats any clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       sw_down <= 1'b0;
        else if (sw_down_stb)             sw_down <= 1'b1;
        else if (sw_up_stb || pd_fall)    sw_down <= 1'b0;
    end

    assign off_req = pd_s || sw_down;

    pdc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst_n(rst_n), .run(state == ST_WARM), .done(settled)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  if (!off_req)     state_nx = ST_WARM;
            ST_WARM: if (off_req)      state_nx = ST_OFF;
                     else if (settled) state_nx = ST_ON;
            ST_ON:   if (off_req)      state_nx = ST_OFF;
            default:                   state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        core_en    = (state != ST_OFF);
        core_ready = (state == ST_ON);
        drop       = (state != ST_OFF) && off_req;
    end

    pdc_invalid u_inv (
        .clk(clk), .rst_n(rst_n), .drop(drop), .busy(conv_busy),
        .done(conv_done), .powered(core_en), .invalid(result_invalid)
    );
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker (
    input logic clk,
    input logic rst_n,
    input logic pd_s,
    input logic pd_fall,
    input logic sw_down,
    input logic sw_up_stb,
    input logic conv_busy,
    input logic core_en,
    input logic core_ready,
    input logic result_invalid
);
    a_r2_pin_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        pd_s |=> !core_en);

    a_r4_sticky_down: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_down && !sw_up_stb && !pd_fall) |=> !core_en);

    a_r8_ready_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |-> core_en);

    a_r8_ready_after_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_ready) |-> $stable(core_en));

    a_r9_loss_marks_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_en) && $past(conv_busy)) |-> result_invalid);

    a_r10_hold_while_off: assert property (@(posedge clk) disable iff (!rst_n)
        (result_invalid && !core_en) |=> result_invalid);
endmodule

bind pwr_gate_ctrl pdc_checker u_pdc_checker (
    .clk(clk), .rst_n(rst_n), .pd_s(pd_s), .pd_fall(pd_fall),
    .sw_down(sw_down), .sw_up_stb(sw_up_stb), .conv_busy(conv_busy),
    .core_en(core_en), .core_ready(core_ready), .result_invalid(result_invalid)
);

// File: tb/test_pwr_gate_ctrl.sv
module test_pwr_gate_ctrl;
    localparam int SETTLE = 5;

    logic clk = 0, rst_n = 0;
    logic pd_pin = 0, sw_down_stb = 0, sw_up_stb = 0, conv_busy = 0, conv_done = 0;
    logic core_en, core_ready, result_invalid;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    pwr_gate_ctrl #(.SYNC_STAGES(2), .SETTLE_CYCLES(SETTLE)) i_pwr_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .sw_down_stb(sw_down_stb),
        .sw_up_stb(sw_up_stb), .conv_busy(conv_busy), .conv_done(conv_done),
        .core_en(core_en), .core_ready(core_ready), .result_invalid(result_invalid)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_down();
        sw_down_stb = 1; @(negedge clk); sw_down_stb = 0;
    endtask

    task automatic pulse_up();
        sw_up_stb = 1; @(negedge clk); sw_up_stb = 0;
    endtask

    task automatic pulse_done();
        conv_done = 1; @(negedge clk); conv_done = 0;
    endtask

    task automatic t_reset();
        wait_n(2);
        check("R1 en in reset", core_en, 0);
        check("R1 ready in reset", core_ready, 0);
        check("R1 invalid in reset", result_invalid, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 en after release", core_en, 0);
        check("R1 invalid after release", result_invalid, 0);
        wait_n(SETTLE + 6);
        check("R8 ready after reset wake", core_ready, 1);
    endtask

    task automatic t_settle();
        int n = 0, k = 0;
        pulse_down(); wait_n(3);
        pulse_up();
        while (!core_en && n < 20) begin @(negedge clk); n++; end
        check("R5 up strobe restores", core_en, 1);
        while (!core_ready && k < 20) begin @(negedge clk); k++; end
        checks++;
        if (k != SETTLE) begin
            failures++;
            $display("FAIL R8 settle delay actual=%0d expected=%0d", k, SETTLE);
        end
    endtask

    task automatic t_pin_off();
        pd_pin = 1; wait_n(3);
        check("R2 pin high disables", core_en, 0);
        check("R8 ready drops with en", core_ready, 0);
        pulse_up(); wait_n(3);
        check("R3 up ignored while pin high", core_en, 0);
        pd_pin = 0; wait_n(SETTLE + 6);
        check("R2 pin low re-enables", core_ready, 1);
    endtask

    task automatic t_sticky_and_pin_clear();
        pulse_down(); wait_n(1);
        check("R4 down strobe disables", core_en, 0);
        wait_n(20);
        check("R4 down is sticky", core_en, 0);
        pd_pin = 1; wait_n(4);
        pd_pin = 0; wait_n(6);
        check("R6 pin pulse clears down", core_en, 1);
        wait_n(SETTLE + 2);
    endtask

    task automatic t_priority();
        sw_down_stb = 1; sw_up_stb = 1; @(negedge clk);
        sw_down_stb = 0; sw_up_stb = 0;
        wait_n(5);
        check("R7 down beats up", core_en, 0);
        pulse_up(); wait_n(3);
        check("R5 up after tie", core_en, 1);
        wait_n(SETTLE + 2);
        pd_pin = 1; wait_n(4);
        pd_pin = 0; wait_n(2);
        pulse_down();
        wait_n(8);
        check("R7 down beats pin fall", core_en, 0);
        pulse_up(); wait_n(SETTLE + 4);
    endtask

    task automatic t_invalid();
        check("R8 ready before busy", core_ready, 1);
        conv_busy = 1;
        pulse_down(); wait_n(2);
        conv_busy = 0;
        check("R9 loss mid-conversion", result_invalid, 1);
        pulse_done(); wait_n(1);
        check("R10 done while off keeps flag", result_invalid, 1);
        pulse_up(); wait_n(SETTLE + 4);
        check("R10 flag survives wake", result_invalid, 1);
        pulse_done(); wait_n(1);
        check("R10 done while on clears", result_invalid, 0);
        pulse_down(); wait_n(3);
        check("R10 idle loss no flag", result_invalid, 0);
        pulse_up(); wait_n(SETTLE + 4);
    endtask

    initial begin
        t_reset();
        t_settle();
        t_pin_off();
        t_sticky_and_pin_clear();
        t_priority();
        t_invalid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule